// File: doc/BRIEF.md
# Interrupt Destination Decode and Dispatch

This block turns one routing entry into a stream of per-processor interrupt strobes. A request carries an 8-bit destination, a destination-mode bit (physical or logical), a 3-bit delivery mode, an 8-bit vector, a trigger-type bit and the index of the input pin that raised it. The block compares the destination against every processor's physical ID, logical ID and present flag to form a target set, reshapes that set according to the delivery mode and the pin, and then walks it one target per clock cycle.

Vectored deliveries raise `irq_strobe` with the vector, trigger type and target index. Non-maskable deliveries raise `nmi_strobe` with the target index. A one-cycle `done` pulse closes every accepted request, and `injected` is raised with it when at least one vectored strobe went out. The upstream routing logic uses `injected` to decide whether a level-triggered source now waits for an end-of-interrupt.

Top module: `intr_route_dispatch`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy`, `irq_strobe`, `nmi_strobe`, `done` and `injected` are low.
- R2: In physical mode (`dest_logical`=0), a destination of 0xFF targets every processor whose present bit is set.
- R3: In physical mode with any other destination, only the lowest-index present processor whose physical ID equals the destination is targeted, even when several IDs match.
- R4: In logical mode (`dest_logical`=1), a destination of 0x00 targets no processor.
- R5: In logical mode with a nonzero destination, every present processor whose 8-bit logical ID shares at least one set bit with the destination is targeted.
- R6: When the final target set is empty, no strobe is issued, `done` is raised in the cycle after the request is accepted, and `injected` stays low.
- R7: Delivery mode 3'b000 (fixed) issues one `irq_strobe` per target, one per consecutive cycle, in ascending processor index, each carrying the request's vector and trigger type, and `injected` is high with `done`.
- R8: Delivery mode 3'b100 (non-maskable) issues one `nmi_strobe` per target in ascending index, never with `irq_strobe`, and `injected` stays low.
- R9: Delivery mode 3'b001 (lowest priority) issues exactly one `irq_strobe`, to the target with the smallest 4-bit `cpu_prio` value, with ties going to the lowest index.
- R10: For pin 0 in fixed or lowest-priority mode, a nonempty target set is replaced by processor 0 alone. An empty set stays empty.
- R11: Any other delivery mode encoding issues no strobe, and it ends with `done` and `injected` low.
- R12: `start` is ignored while `busy` is high, and changes on the request inputs during a dispatch do not alter that dispatch.
- R13: `busy` rises in the cycle after a request is accepted and stays high through `done`. `done` lasts one cycle and comes directly after the last strobe, so N targets take N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| dest | input | 8 | Destination field |
| dest_logical | input | 1 | 0 = physical match, 1 = logical match |
| dmode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, 100 non-maskable |
| vector | input | 8 | Interrupt vector |
| level_trig | input | 1 | Trigger type carried with vectored strobes |
| pin | input | PIN_W | Index of the raising input pin |
| cpu_present | input | N_CPU | Per-processor present flags |
| cpu_phys_id | input | 8*N_CPU | Physical IDs, processor i at bits [8i+7:8i] |
| cpu_logical_id | input | 8*N_CPU | Logical IDs, processor i at bits [8i+7:8i] |
| cpu_prio | input | PRIO_W*N_CPU | Arbitration priority, lower wins |
| busy | output | 1 | A dispatch is in progress |
| irq_strobe | output | 1 | Vectored interrupt to `tgt_cpu` this cycle |
| nmi_strobe | output | 1 | Non-maskable interrupt to `tgt_cpu` this cycle |
| tgt_cpu | output | CPU_W | Target processor index of the current strobe |
| irq_vector | output | 8 | Vector of the dispatch in progress |
| irq_level | output | 1 | Trigger type of the dispatch in progress |
| done | output | 1 | One-cycle end-of-dispatch pulse |
| injected | output | 1 | With `done`: at least one vectored strobe was issued |

## Verification
A corrupted remaining-target register shows up at once as a wrong `tgt_cpu`, a skipped or repeated index, or a strobe count that does not match the set, and the next strobe cycle already shows it. A wrong state in the sequencer shows up as strobes outside `busy`, a missing or doubled `done`, or a cycle count other than targets plus one. A mis-decoded target set or a wrong arbitration pick is caught by the first strobe of the affected request, which is at most one cycle after acceptance. A stale capture register shows up as vector or trigger changes within a burst, or as a dispatch that takes on inputs applied while busy.

// File: rtl/intr_route_pkg.sv
`timescale 1ns/1ps
package intr_route_pkg;
  localparam int DEST_W  = 8;
  localparam int VEC_W   = 8;
  localparam int DMODE_W = 3;

  localparam logic [DMODE_W-1:0] DM_FIXED  = 3'b000;
  localparam logic [DMODE_W-1:0] DM_LOWEST = 3'b001;
  localparam logic [DMODE_W-1:0] DM_NMI    = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    logic             level;
    logic             nmi;
  } dispatch_hdr_t;
endpackage

// File: rtl/intr_target_mask.sv
`timescale 1ns/1ps
module intr_target_mask #(
  parameter int N_CPU = 8,
  parameter int ID_W  = intr_route_pkg::DEST_W
) (
  input  logic [ID_W-1:0]       dest,
  input  logic                  logical,
  input  logic [N_CPU-1:0]      present,
  input  logic [N_CPU*ID_W-1:0] phys_ids,
  input  logic [N_CPU*ID_W-1:0] log_ids,
  output logic [N_CPU-1:0]      target_mask
);
  localparam logic [ID_W-1:0] ALL_ONES = {ID_W{1'b1}};

  function automatic logic logical_hit(input logic [ID_W-1:0] a,
                                       input logic [ID_W-1:0] b);
    return |(a & b);
  endfunction

  function automatic logic [N_CPU-1:0] keep_lowest(input logic [N_CPU-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  logic [N_CPU-1:0] phys_eq;
  logic [N_CPU-1:0] log_eq;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cmp
    assign phys_eq[g] = present[g] && (phys_ids[g*ID_W +: ID_W] == dest);
    assign log_eq[g]  = present[g] && logical_hit(log_ids[g*ID_W +: ID_W], dest);
  end

  always_comb begin
    if (!logical) begin
      if (dest == ALL_ONES) target_mask = present;
      else                  target_mask = keep_lowest(phys_eq);
    end else begin
      if (dest == '0) target_mask = '0;
      else            target_mask = log_eq;
    end
  end
endmodule

// File: rtl/intr_lowprio_pick.sv
`timescale 1ns/1ps
module intr_lowprio_pick #(
  parameter int N_CPU  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_CPU-1:0]        cand,
  input  logic [N_CPU*PRIO_W-1:0] prio,
  output logic [N_CPU-1:0]        pick_oh
);
  logic [PRIO_W-1:0] best_p;
  logic [N_CPU-1:0]  best_oh;
  logic              found;

  always_comb begin
    best_p  = '0;
    best_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < N_CPU; i++) begin
      if (cand[i] && (!found || (prio[i*PRIO_W +: PRIO_W] < best_p))) begin
        found   = 1'b1;
        best_p  = prio[i*PRIO_W +: PRIO_W];
        best_oh = '0;
        best_oh[i] = 1'b1;
      end
    end
    pick_oh = best_oh;
  end
endmodule

// File: rtl/intr_dispatch_seq.sv
`timescale 1ns/1ps
module intr_dispatch_seq
  import intr_route_pkg::*;
#(
  parameter int N_CPU = 8,
  parameter int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CPU-1:0]   load_mask,
  input  dispatch_hdr_t      load_hdr,
  output logic               busy,
  output logic               irq_strobe,
  output logic               nmi_strobe,
  output logic [CPU_W-1:0]   tgt_cpu,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               irq_level,
  output logic               done,
  output logic               injected
);
  function automatic logic [CPU_W-1:0] oh_to_idx(input logic [N_CPU-1:0] oh);
    logic [CPU_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_CPU; i++)
      if (oh[i]) idx = idx | CPU_W'(i);
    return idx;
  endfunction

  seq_state_e       state_q;
  logic [N_CPU-1:0] rem_q;
  dispatch_hdr_t    hdr_q;
  logic             inj_q;
  logic [N_CPU-1:0] low_oh;
  logic [N_CPU-1:0] rem_next;

  assign low_oh   = rem_q & (~rem_q + 1'b1);
  assign rem_next = rem_q & ~low_oh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      hdr_q   <= '0;
      inj_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load) begin
          rem_q   <= load_mask;
          hdr_q   <= load_hdr;
          inj_q   <= (load_mask != '0) && !load_hdr.nmi;
          state_q <= (load_mask != '0) ? ST_RUN : ST_FIN;
        end
        ST_RUN: begin
          rem_q <= rem_next;
          if (rem_next == '0) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign irq_strobe = (state_q == ST_RUN) && !hdr_q.nmi;
  assign nmi_strobe = (state_q == ST_RUN) &&  hdr_q.nmi;
  assign tgt_cpu    = oh_to_idx(low_oh);
  assign irq_vector = hdr_q.vector;
  assign irq_level  = hdr_q.level;
  assign done       = (state_q == ST_FIN);
  assign injected   = (state_q == ST_FIN) && inj_q;
endmodule

// File: rtl/intr_route_dispatch.sv
`timescale 1ns/1ps
module intr_route_dispatch
  import intr_route_pkg::*;
#(
  parameter int N_CPU  = 8,
  parameter int PIN_W  = 5,
  parameter int PRIO_W = 4,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DEST_W-1:0]       dest,
  input  logic                    dest_logical,
  input  logic [DMODE_W-1:0]      dmode,
  input  logic [VEC_W-1:0]        vector,
  input  logic                    level_trig,
  input  logic [PIN_W-1:0]        pin,
  input  logic [N_CPU-1:0]        cpu_present,
  input  logic [N_CPU*DEST_W-1:0] cpu_phys_id,
  input  logic [N_CPU*DEST_W-1:0] cpu_logical_id,
  input  logic [N_CPU*PRIO_W-1:0] cpu_prio,
  output logic                    busy,
  output logic                    irq_strobe,
  output logic                    nmi_strobe,
  output logic [CPU_W-1:0]        tgt_cpu,
  output logic [VEC_W-1:0]        irq_vector,
  output logic                    irq_level,
  output logic                    done,
  output logic                    injected
);
  localparam logic [N_CPU-1:0] CPU0_ONLY = N_CPU'(1);

  logic [N_CPU-1:0] raw_mask;
  logic [N_CPU-1:0] pick_oh;
  logic [N_CPU-1:0] final_mask;
  logic             accept;
  logic             pin_zero;
  dispatch_hdr_t    hdr;

  intr_target_mask #(.N_CPU(N_CPU), .ID_W(DEST_W)) u_mask (
    .dest        (dest),
    .logical     (dest_logical),
    .present     (cpu_present),
    .phys_ids    (cpu_phys_id),
    .log_ids     (cpu_logical_id),
    .target_mask (raw_mask)
  );

  intr_lowprio_pick #(.N_CPU(N_CPU), .PRIO_W(PRIO_W)) u_pick (
    .cand    (raw_mask),
    .prio    (cpu_prio),
    .pick_oh (pick_oh)
  );

  assign pin_zero = (pin == '0);
  assign accept   = start && !busy;

  always_comb begin
    final_mask = '0;
    unique case (dmode)
      DM_FIXED:  final_mask = (pin_zero && raw_mask != '0) ? CPU0_ONLY : raw_mask;
      DM_LOWEST: if (raw_mask != '0) final_mask = pin_zero ? CPU0_ONLY : pick_oh;
      DM_NMI:    final_mask = raw_mask;
      default:   final_mask = '0;
    endcase
  end

  assign hdr.vector = vector;
  assign hdr.level  = level_trig;
  assign hdr.nmi    = (dmode == DM_NMI);

  intr_dispatch_seq #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_mask  (final_mask),
    .load_hdr   (hdr),
    .busy       (busy),
    .irq_strobe (irq_strobe),
    .nmi_strobe (nmi_strobe),
    .tgt_cpu    (tgt_cpu),
    .irq_vector (irq_vector),
    .irq_level  (irq_level),
    .done       (done),
    .injected   (injected)
  );
endmodule

// File: rtl/intr_route_checker.sv
`timescale 1ns/1ps
module intr_route_checker
  import intr_route_pkg::*;
#(
  parameter int N_CPU = 8,
  parameter int CPU_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq_strobe,
  input logic             nmi_strobe,
  input logic [CPU_W-1:0] tgt_cpu,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_level,
  input logic             done,
  input logic             injected,
  input logic [N_CPU-1:0] pick_oh
);
  logic any_strobe;
  assign any_strobe = irq_strobe || nmi_strobe;

  assert_strobe_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_strobe && nmi_strobe));

  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && $past(any_strobe)) |-> (tgt_cpu > $past(tgt_cpu)));

  assert_fields_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(irq_vector) && $stable(irq_level)));

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_strobe_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (busy && !done));

  assert_busy_until_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_inj_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    injected |-> done);

  assert_nmi_no_inj_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nmi_strobe) && done) |-> !injected);

  assert_single_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
endmodule

bind intr_route_dispatch intr_route_checker #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .irq_strobe (irq_strobe),
  .nmi_strobe (nmi_strobe),
  .tgt_cpu    (tgt_cpu),
  .irq_vector (irq_vector),
  .irq_level  (irq_level),
  .done       (done),
  .injected   (injected),
  .pick_oh    (pick_oh)
);

// File: tb/intr_route_dispatch_bench.sv
`timescale 1ns/1ps
module intr_route_dispatch_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  dest = '0;
  logic        dest_logical = 1'b0;
  logic [2:0]  dmode = '0;
  logic [7:0]  vector = '0;
  logic        level_trig = 1'b0;
  logic [4:0]  pin = '0;
  logic [N-1:0] cpu_present;
  logic [N*8-1:0] cpu_phys_id, cpu_logical_id;
  logic [N*4-1:0] cpu_prio;
  logic        busy, irq_strobe, nmi_strobe, done, injected, irq_level;
  logic [2:0]  tgt_cpu;
  logic [7:0]  irq_vector;

  logic [7:0] phys [N];
  logic [7:0] lid  [N];
  logic [3:0] pri  [N];

  always_comb
    for (int i = 0; i < N; i++) begin
      cpu_phys_id[i*8 +: 8]    = phys[i];
      cpu_logical_id[i*8 +: 8] = lid[i];
      cpu_prio[i*4 +: 4]       = pri[i];
    end

  always #2.5 clk = ~clk;

  intr_route_dispatch u_intr_route_dispatch (.*);

  int checks = 0;
  int fails = 0;
  logic [8:0] exp_q [$];
  logic       inj_q [$];
  logic [7:0] exp_vec;
  logic       exp_lvl;
  string      exp_tag;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Expected target set, written from the requirements
  function automatic logic [N-1:0] model(input logic [7:0] d, input logic lg,
                                         input logic [2:0] m, input logic [4:0] p);
    logic [N-1:0] s = '0;
    int best = -1;
    if (!lg) begin
      if (d == 8'hFF) s = cpu_present;                       // R2
      else for (int i = N-1; i >= 0; i--)                    // R3
        if (cpu_present[i] && phys[i] == d) s = N'(1) << i;
    end else if (d != 0) begin                               // R4, R5
      for (int i = 0; i < N; i++)
        if (cpu_present[i] && (lid[i] & d) != 0) s[i] = 1'b1;
    end
    case (m)
      3'b000: if (s != 0 && p == 0) s = N'(1);               // R10
      3'b001: if (s != 0) begin                              // R9
        if (p == 0) s = N'(1);
        else begin
          for (int i = 0; i < N; i++)
            if (s[i] && (best < 0 || pri[i] < pri[best])) best = i;
          s = N'(1) << best;
        end
      end
      3'b100: ;
      default: s = '0;                                       // R11
    endcase
    return s;
  endfunction

  // Monitor: pop and compare
  always @(negedge clk) if (rst_n) begin
    if (irq_strobe || nmi_strobe) begin
      if (exp_q.size() == 0)
        check(0, {exp_tag, " unexpected strobe"}, {irq_strobe, nmi_strobe, tgt_cpu}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(e == {nmi_strobe, 5'd0, tgt_cpu}, {exp_tag, " target"},
              {nmi_strobe, 5'd0, tgt_cpu}, e);
        if (irq_strobe)
          check({irq_vector, irq_level} == {exp_vec, exp_lvl}, "R7 vector/trigger",
                {irq_vector, irq_level}, {exp_vec, exp_lvl});
      end
    end
    if (done) begin
      logic ei;
      ei = (inj_q.size() != 0) ? inj_q.pop_front() : 1'b0;
      check(injected == ei, {exp_tag, " R6 injected"}, injected, ei);
      check(exp_q.size() == 0, {exp_tag, " missing strobes"}, exp_q.size(), 0);
      exp_q.delete();
    end
  end

  // Driver
  task automatic dispatch(input logic [7:0] d, input logic lg, input logic [2:0] m,
                          input logic [7:0] v, input logic lv, input logic [4:0] p,
                          input bit poke, input string tag);
    logic [N-1:0] s;
    int cyc;
    @(negedge clk);
    dest = d; dest_logical = lg; dmode = m; vector = v; level_trig = lv; pin = p;
    s = model(d, lg, m, p);
    exp_tag = tag; exp_vec = v; exp_lvl = lv;
    for (int i = 0; i < N; i++)
      if (s[i]) exp_q.push_back({(m == 3'b100), 5'd0, 3'(i)});
    inj_q.push_back(s != 0 && m != 3'b100);
    start = 1'b1;
    @(negedge clk);
    cyc = 1;
    if (poke) begin   // R12: new request while busy
      dest = 8'hFF; dest_logical = 1'b0; dmode = 3'b100; vector = ~v; level_trig = ~lv; pin = 5'd7;
    end else start = 1'b0;
    check(busy == 1'b1, {tag, " R13 busy"}, busy, 1);
    while (!done) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    start = 1'b0;
    check(cyc == $countones(s) + 1, {tag, " R13 cycles"}, cyc, $countones(s) + 1);
    @(negedge clk);
    check(!busy && !irq_strobe && !nmi_strobe, {tag, " R12 idle after"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cpu_present = 8'b1011_1111;  // processor 6 absent
    for (int i = 0; i < N; i++) begin
      phys[i] = 8'h10 + 8'(i);
      lid[i]  = 8'(1) << i;
      pri[i]  = 4'd9 + 4'(i % 3);
    end
    phys[2] = 8'h22; phys[5] = 8'h22;
    lid[3]  = 8'h81; lid[6] = 8'h81;
    pri[1]  = 4'd2;  pri[4] = 4'd2;

    repeat (3) @(negedge clk);
    check(!busy && !irq_strobe && !nmi_strobe && !done && !injected, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !injected, "R1 after reset", busy, 0);

    dispatch(8'hFF, 0, 3'b000, 8'h41, 0, 5'd3, 0, "R2 broadcast fixed");
    dispatch(8'h22, 0, 3'b000, 8'h42, 1, 5'd4, 0, "R3 first phys match");
    dispatch(8'h16, 0, 3'b000, 8'h43, 0, 5'd4, 0, "R3 absent match");
    dispatch(8'h55, 0, 3'b000, 8'h44, 0, 5'd4, 0, "R6 no phys match");
    dispatch(8'h00, 1, 3'b000, 8'h45, 0, 5'd2, 0, "R4 logical zero");
    dispatch(8'h81, 1, 3'b000, 8'h46, 1, 5'd2, 0, "R5 logical match");
    dispatch(8'hF0, 1, 3'b100, 8'h47, 0, 5'd2, 0, "R8 nmi logical");
    dispatch(8'hFF, 0, 3'b100, 8'h48, 1, 5'd0, 0, "R8 nmi broadcast pin0");
    dispatch(8'hFF, 1, 3'b001, 8'h49, 0, 5'd5, 0, "R9 lowest tie");
    pri[1] = 4'd7;
    dispatch(8'hFF, 1, 3'b001, 8'h4A, 1, 5'd5, 0, "R9 lowest unique");
    dispatch(8'h0C, 1, 3'b001, 8'h4B, 0, 5'd5, 0, "R9 lowest subset");
    dispatch(8'hFF, 0, 3'b000, 8'h4C, 1, 5'd0, 0, "R10 pin0 fixed");
    dispatch(8'hF0, 1, 3'b001, 8'h4D, 0, 5'd0, 0, "R10 pin0 lowest");
    dispatch(8'h55, 0, 3'b000, 8'h4E, 0, 5'd0, 0, "R10 pin0 empty");
    dispatch(8'hFF, 0, 3'b010, 8'h4F, 0, 5'd3, 0, "R11 mode 010");
    dispatch(8'hFF, 0, 3'b111, 8'h50, 0, 5'd3, 0, "R11 mode 111");
    dispatch(8'h81, 1, 3'b000, 8'h51, 1, 5'd9, 1, "R12 start while busy");
    dispatch(8'h11, 0, 3'b000, 8'h52, 0, 5'd1, 0, "R7 single after poke");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule